// File: doc/BRIEF.md
# Single-Wire Bus Slave: Reset Responder and Write-Slot Receiver

This block is the device end of an open-drain single-wire bus. It runs from the system clock plus a one-cycle strobe that marks each elapsed microsecond, and it watches an already synchronized copy of the line. When the master holds the line low long enough, the block treats it as a bus reset. It then waits a fixed time after the line rises and pulls the line low itself for a bounded time, so the master knows a device is present.

Outside the reset and presence sequence, every falling edge made by the master opens a write slot. The block samples the line level a fixed number of microseconds into the slot. A slot the master released early gives a 1, and a slot still held low gives a 0. The bits are assembled least significant first. Each completed byte is presented with a one-cycle valid strobe. A reset at any time throws away a partly received byte and starts the presence sequence again.

Top module: `sw_slave_rx`

## Requirements
- R1: When the line has been low for RST_US (default 480) consecutive microsecond ticks, `reset_seen` is high for exactly one clock, in the clock after that tick. It does not repeat while the line stays low.
- R2: After a reset, the rising edge of the line starts the response delay. `pull_low` rises in the clock after the WAIT_US-th (default 30) tick that follows that rising edge. A tick in the same clock as the edge is not counted.
- R3: `pull_low` stays high for exactly PRES_US (default 120) ticks, then falls after the last of them. It is never high outside this presence window.
- R4: The falling edge caused by the block's own presence pulse, and any low level while the pulse is driven, produce no received bit.
- R5: Outside the reset and presence sequence, a falling edge opens a slot. The bit is the line level at the SAMPLE_US-th (default 30) tick after that edge: 1 = released early, 0 = held low.
- R6: Bits enter least significant first. After the 8th bit, `rx_byte` takes the byte and `byte_valid` is high for one clock, one clock after the sampling clock. `rx_byte` is unchanged at all other times.
- R7: A reset clears the bit count, so the next 8 slots form a whole new byte.
- R8: After a sample, the line must be high again before a new slot can open. A low held past the sample point, but shorter than a reset, yields exactly one 0 bit.
- R9: While `rst_n` is low at a clock edge, `pull_low`, `byte_valid`, `reset_seen` and `rx_byte` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-clock strobe per elapsed microsecond |
| line_in | input | 1 | Synchronized level of the bus line |
| pull_low | output | 1 | Enable for the open-drain pulldown |
| rx_byte | output | 8 | Last completed received byte |
| byte_valid | output | 1 | One-clock strobe when `rx_byte` is updated |
| reset_seen | output | 1 | One-clock strobe when a bus reset is recognized |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a byte. Only the effect on the next byte shows that the partial bits were dropped. The bench sends three slots, then a full reset and presence sequence, and then a complete byte. It also holds the line low past the sample point but short of the reset length. Both times it checks the byte that comes out against a cycle-by-cycle behavioural model, which runs in step with the design on every clock.

// File: rtl/sw_pkg.sv
// Shared types for the single-wire slave receiver.
// Assumes nothing beyond a single clock domain.
package sw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a master falling edge
        ST_SLOT  = 3'd1,   // inside a write slot, counting to sample point
        ST_RECOV = 3'd2,   // bit taken, waiting for line release
        ST_ARM   = 3'd3,   // reset seen, waiting for line to rise
        ST_WAIT  = 3'd4,   // delay before presence pulse
        ST_PRES  = 3'd5    // driving the presence pulse
    } sw_state_e;
endpackage

// File: rtl/sw_low_timer.sv
// Edge detector and low-width timer for the bus line.
// Produces falling/rising edge strobes and a reset-hit strobe when the line
// has been low for RST_US ticks. Assumes line_in is already synchronized.
module sw_low_timer #(
    parameter int RST_US = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_in,
    output logic fall_o,
    output logic rise_o,
    output logic rst_hit_o
);
    localparam int LOW_W = $clog2(RST_US + 1);

    logic             line_q;
    logic [LOW_W-1:0] low_us;

    // Delayed line copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_in;
    end

    // Saturating count of ticks spent low; cleared while high.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   low_us <= '0;
        else if (line_in)                             low_us <= '0;
        else if (us_tick && low_us != LOW_W'(RST_US)) low_us <= low_us + 1'b1;
    end

    // Edge and reset strobes from current and delayed levels.
    always_comb begin
        fall_o    = line_q & ~line_in;
        rise_o    = ~line_q & line_in;
        rst_hit_o = ~line_in & us_tick & (low_us == LOW_W'(RST_US - 1));
    end

    // R1
    low_hit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit_o |=> !rst_hit_o);
endmodule

// File: rtl/sw_slot_ctrl.sv
// Sequencer for presence response and write-slot timing.
// Consumes edge and reset strobes; drives the pulldown and a bit strobe.
// Assumes one us_tick per microsecond and parameters inside bus limits.
module sw_slot_ctrl
    import sw_pkg::*;
#(
    parameter int WAIT_US   = 30,
    parameter int PRES_US   = 120,
    parameter int SAMPLE_US = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_in,
    input  logic fall_i,
    input  logic rise_i,
    input  logic rst_hit_i,
    output logic pull_low_o,
    output logic reset_seen_o,
    output logic bit_stb_o,
    output logic bit_val_o
);
    localparam int MAX_US = (WAIT_US > PRES_US) ?
                            ((WAIT_US > SAMPLE_US) ? WAIT_US : SAMPLE_US) :
                            ((PRES_US > SAMPLE_US) ? PRES_US : SAMPLE_US);
    localparam int CNT_W  = $clog2(MAX_US + 1);

    sw_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             at_sample;

    // Sample point of the current slot.
    always_comb begin
        at_sample = (state == ST_SLOT) && us_tick && (cnt == CNT_W'(SAMPLE_US - 1));
        bit_stb_o = at_sample && !rst_hit_i;
        bit_val_o = line_in;
    end

    // Main sequencer: reset takes priority from every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            pull_low_o   <= 1'b0;
            reset_seen_o <= 1'b0;
        end else begin
            reset_seen_o <= rst_hit_i;
            if (rst_hit_i) begin
                state      <= ST_ARM;
                cnt        <= '0;
                pull_low_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: if (fall_i) begin
                        state <= ST_SLOT;
                        cnt   <= '0;
                    end
                    ST_SLOT: if (us_tick) begin
                        if (cnt == CNT_W'(SAMPLE_US - 1)) begin
                            state <= ST_RECOV;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_RECOV: if (line_in) state <= ST_IDLE;
                    ST_ARM: if (rise_i) begin
                        state <= ST_WAIT;
                        cnt   <= '0;
                    end
                    ST_WAIT: if (us_tick) begin
                        if (cnt == CNT_W'(WAIT_US - 1)) begin
                            state      <= ST_PRES;
                            cnt        <= '0;
                            pull_low_o <= 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_PRES: if (us_tick) begin
                        if (cnt == CNT_W'(PRES_US - 1)) begin
                            state      <= ST_IDLE;
                            cnt        <= '0;
                            pull_low_o <= 1'b0;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R3
    pres_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRES) |-> pull_low_o);
    // R2
    pres_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low_o) |-> ($past(state) == ST_WAIT));
    // R4
    no_self_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low_o |-> !bit_stb_o);
endmodule

// File: rtl/sw_byte_shifter.sv
// LSB-first deserializer with a completion strobe.
// Assumes bit_stb_i is a single-cycle pulse; clear_i aborts a partial word.
module sw_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic              clear_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              byte_valid_o
);
    localparam int BC_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [BC_W-1:0]   bit_cnt;
    logic [DATA_W-1:0] shifted;

    // Next shift value with the new bit entering at the top.
    always_comb shifted = {bit_val_i, shreg[DATA_W-1:1]};

    // Shift, count and publish a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg        <= '0;
            bit_cnt      <= '0;
            rx_byte_o    <= '0;
            byte_valid_o <= 1'b0;
        end else begin
            byte_valid_o <= 1'b0;
            if (clear_i) begin
                bit_cnt <= '0;
            end else if (bit_stb_i) begin
                shreg <= shifted;
                if (bit_cnt == BC_W'(DATA_W - 1)) begin
                    bit_cnt      <= '0;
                    rx_byte_o    <= shifted;
                    byte_valid_o <= 1'b1;
                end else bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R6
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);
    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_o |-> $stable(rx_byte_o));
    // R7
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (bit_cnt == '0));
endmodule

// File: rtl/sw_slave_rx.sv
// Top of the single-wire slave: reset detection, presence response and
// write-slot reception into bytes. Assumes a synchronized line input and
// an external open-drain driver controlled by pull_low.
module sw_slave_rx #(
    parameter int RST_US    = 480,
    parameter int WAIT_US   = 30,
    parameter int PRES_US   = 120,
    parameter int SAMPLE_US = 30,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              line_in,
    output logic              pull_low,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              reset_seen
);
    logic fall, rise, rst_hit, bit_stb, bit_val;

    sw_low_timer #(.RST_US(RST_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
        .fall_o(fall), .rise_o(rise), .rst_hit_o(rst_hit)
    );

    sw_slot_ctrl #(.WAIT_US(WAIT_US), .PRES_US(PRES_US), .SAMPLE_US(SAMPLE_US)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
        .fall_i(fall), .rise_i(rise), .rst_hit_i(rst_hit),
        .pull_low_o(pull_low), .reset_seen_o(reset_seen),
        .bit_stb_o(bit_stb), .bit_val_o(bit_val)
    );

    sw_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_stb_i(bit_stb), .bit_val_i(bit_val),
        .clear_i(rst_hit), .rx_byte_o(rx_byte), .byte_valid_o(byte_valid)
    );

    // R1
    reset_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !reset_seen);
endmodule

// File: tb/sim_sw_slave_rx.sv
module sim_sw_slave_rx;
    localparam int RST_US = 480, WAIT_US = 30, PRES_US = 120, SAMPLE_US = 30;
    localparam int TICK_DIV = 5;

    logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, m_low = 1'b0;
    logic pull_low, byte_valid, reset_seen;
    logic [7:0] rx_byte;
    wire line = !(m_low || pull_low);

    int checks = 0, fails = 0, tick_total = 0, cyc = 0;
    int bv_count = 0, rst_count = 0, pull_clks = 0;

    always #2 clk = ~clk;   // 250 MHz

    sw_slave_rx u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line),
        .pull_low(pull_low), .rx_byte(rx_byte),
        .byte_valid(byte_valid), .reset_seen(reset_seen)
    );

    // Microsecond tick source.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (us_tick) tick_total <= tick_total + 1;
    end

    // Behavioural reference model.
    int ms, mc, mlow, mbits;
    logic [7:0] msh, e_rx;
    logic e_pull, e_bv, e_rst, mprev, ln, hit;
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mc = 0; mlow = 0; mbits = 0; msh = 0; e_rx = 0;
            e_pull = 0; e_bv = 0; e_rst = 0; mprev = 1;
        end else begin
            ln  = line;
            hit = !ln && us_tick && (mlow == RST_US - 1);
            if (ln) mlow = 0;
            else if (us_tick && mlow < RST_US) mlow = mlow + 1;
            e_rst = hit;
            e_bv  = 0;
            if (hit) begin
                ms = 3; mc = 0; e_pull = 0; mbits = 0;
            end else begin
                case (ms)
                    0: if (mprev && !ln) begin ms = 1; mc = 0; end
                    1: if (us_tick) begin
                        if (mc == SAMPLE_US - 1) begin
                            ms = 2; mc = 0;
                            msh = {ln, msh[7:1]};
                            mbits = mbits + 1;
                            if (mbits == 8) begin e_rx = msh; e_bv = 1; mbits = 0; end
                        end else mc = mc + 1;
                    end
                    2: if (ln) ms = 0;
                    3: if (!mprev && ln) begin ms = 4; mc = 0; end
                    4: if (us_tick) begin
                        if (mc == WAIT_US - 1) begin ms = 5; mc = 0; e_pull = 1; end
                        else mc = mc + 1;
                    end
                    5: if (us_tick) begin
                        if (mc == PRES_US - 1) begin ms = 0; mc = 0; e_pull = 0; end
                        else mc = mc + 1;
                    end
                    default: ms = 0;
                endcase
            end
            mprev = ln;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Per-clock comparison and event counting, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pull_low === e_pull, "R2 R3 pull_low", pull_low, e_pull);
            chk(byte_valid === e_bv, "R6 byte_valid", byte_valid, e_bv);
            chk(rx_byte === e_rx, "R5 R6 rx_byte", rx_byte, e_rx);
            chk(reset_seen === e_rst, "R1 reset_seen", reset_seen, e_rst);
            if (byte_valid) bv_count++;
            if (reset_seen) rst_count++;
            if (pull_low) pull_clks++;
        end
    end

    task automatic wait_ticks(input int n);
        int t0 = tick_total;
        while (tick_total < t0 + n) @(negedge clk);
    endtask

    task automatic low_for(input int lo, input int hi);
        m_low = 1'b1; wait_ticks(lo);
        m_low = 1'b0; wait_ticks(hi);
    endtask

    task automatic bus_reset();
        low_for(RST_US + 20, WAIT_US + PRES_US + 40);
    endtask

    task automatic send_bit(input bit b);
        if (b) low_for(5, 65); else low_for(65, 5);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(pull_low === 0 && byte_valid === 0 && reset_seen === 0, "R9 ctrl outputs after reset",
            {pull_low, byte_valid, reset_seen}, 0);
        chk(rx_byte === 8'h00, "R9 rx_byte after reset", rx_byte, 0);
        rst_n = 1'b1;
        wait_ticks(10);

        bus_reset();
        chk(rst_count == 1, "R1 one reset strobe", rst_count, 1);
        chk(pull_clks == PRES_US * TICK_DIV, "R3 presence width", pull_clks, PRES_US * TICK_DIV);
        // R4: own presence edge must not count as a bit
        chk(bv_count == 0, "R4 no byte from presence", bv_count, 0);

        send_byte(8'hA5);
        chk(bv_count == 1, "R6 one strobe per byte", bv_count, 1);
        chk(rx_byte === 8'hA5, "R5 R6 byte A5 LSB first", rx_byte, 8'hA5);

        send_byte(8'h3C);
        chk(rx_byte === 8'h3C, "R5 R6 byte 3C", rx_byte, 8'h3C);

        // R7: partial byte then reset
        send_bit(1); send_bit(1); send_bit(0);
        bus_reset();
        chk(rst_count == 2, "R1 second reset strobe", rst_count, 2);
        chk(bv_count == 2, "R7 partial byte dropped", bv_count, 2);
        send_byte(8'h81);
        chk(rx_byte === 8'h81, "R7 fresh byte after reset", rx_byte, 8'h81);

        // R8: long low below reset length yields one 0 bit
        low_for(200, 5);
        for (int i = 0; i < 7; i++) send_bit(1);
        chk(rx_byte === 8'hFE, "R8 long low is one bit", rx_byte, 8'hFE);
        chk(bv_count == 4, "R8 byte count", bv_count, 4);
        chk(rst_count == 2, "R1 no reset from long low", rst_count, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule